// File: doc/BRIEF.md
# UART FIFO Interrupt and Status Generator

This block produces the receive and transmit interrupt requests and the transmitter-empty status bits for one UART channel with 64-entry transmit and receive FIFOs. It does not hold data. It watches the fill levels reported by the FIFOs, the busy flag of the transmit shift register, the programmed trigger thresholds and a per-bit tick from the baud logic. From these it decides when software must be told to drain the receiver or refill the transmitter.

There are three interrupt sources. A receive-ready request follows the receive FIFO level against its threshold. A receive-idle timeout counts bit ticks while data is waiting and nothing new arrives. A transmit request is latched when the transmit side needs service. In full-duplex operation the transmit request fires when the level drops to the threshold or when the FIFO drains. In half-duplex operation it fires only after the shift register has also finished. An identification code reports the most urgent enabled source. Reading that code acknowledges a pending transmit request when that request is the one shown.

Top module: `uart_fifo_irq`

## Requirements
- R1: `rx_rdy_irq_o` is 1 exactly when `rx_en_i` is 1, `rx_level_i` is nonzero and `rx_level_i >= rx_trig_i`; it follows the inputs in the same cycle.
- R2: With `rx_level_i` nonzero, `rx_tmo_irq_o` rises in the cycle after the (4*`frame_bits_i`+12)-th consecutive `bit_tick_i` counted since the last receive event. It never rises while the receive FIFO is empty.
- R3: `thr_empty_o` is 1 exactly when `tx_level_i` is 0, whatever the state of `tsr_busy_i`.
- R4: `tx_empty_o` is 1 exactly when `tx_level_i` is 0 and `tsr_busy_i` is 0, so it is never 1 while `thr_empty_o` is 0.
- R5: With `half_duplex_i`=0, a transmit request is latched in the cycle after `tx_level_i` moves from above `tx_trig_i` to at or below it, or from nonzero to zero. In the threshold case `thr_empty_o` and `tx_empty_o` read 0; in the drained case `thr_empty_o` reads 1.
- R6: With `half_duplex_i`=1, a transmit request is latched only in the cycle after the condition (`tx_level_i`=0 and `tsr_busy_i`=0) becomes true. A threshold crossing and a drain while the shift register is busy latch nothing.
- R7: `irq_id_o` encodes the highest enabled source. The codes are 4'b1100 for timeout, 4'b0100 for receive-ready, 4'b0010 for transmit and 4'b0001 for none. With parameter TMO_FIRST=1 the order is timeout, then receive-ready, then transmit. `irq_o` is 1 whenever the code is not 4'b0001.
- R8: A pulse on `rx_read_i` or `rx_char_i` clears the timeout in the next cycle and restarts the idle count from zero.
- R9: A pulse on `id_read_i` clears the pending transmit request only when `irq_id_o` shows 4'b0010 in that cycle. Any rise of `tx_level_i` also clears it.
- R10: When `tx_en_i` is 0, `tx_irq_o` is 0 and transmit is absent from `irq_id_o`, but a latched request is kept and reappears once `tx_en_i` returns to 1. When `rx_en_i` is 0, both receive interrupts are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_level_i | input | 7 | Receive FIFO fill level, 0 to 64 |
| tx_level_i | input | 7 | Transmit FIFO fill level, 0 to 64 |
| tsr_busy_i | input | 1 | Transmit shift register holds a character |
| rx_trig_i | input | 7 | Receive-ready threshold |
| tx_trig_i | input | 7 | Transmit threshold |
| frame_bits_i | input | 4 | Bits per character frame |
| bit_tick_i | input | 1 | One pulse per bit time |
| rx_char_i | input | 1 | A new character was received |
| rx_read_i | input | 1 | A byte was read from the receive FIFO |
| id_read_i | input | 1 | Interrupt identification code is being read |
| half_duplex_i | input | 1 | Half-duplex transmit interrupt mode |
| rx_en_i | input | 1 | Enable for both receive interrupts |
| tx_en_i | input | 1 | Enable for the transmit interrupt |
| rx_rdy_irq_o | output | 1 | Receive-ready interrupt |
| rx_tmo_irq_o | output | 1 | Receive idle timeout interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |
| thr_empty_o | output | 1 | Transmit FIFO empty status |
| tx_empty_o | output | 1 | Transmit FIFO and shift register empty status |
| irq_id_o | output | 4 | Prioritized interrupt identification code |
| irq_o | output | 1 | Any enabled interrupt pending |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. Transmitter-empty status always implies FIFO-empty status. A timeout never appears unless the receive FIFO held data. Receive events and reads knock the timeout down in the next cycle. A rise in transmit level drops the pending transmit request. In half-duplex mode a new transmit request only follows a fully idle transmitter. When TMO_FIRST is set, a timeout always wins the identification code.

Other behaviour needs a prepared history and is left to the bench's scenarios. This covers the exact tick on which the idle timeout fires for different frame lengths and the restart of the count after a new character. It also covers the difference between a threshold crossing and a drain, the acknowledge that only works when transmit is the source shown, and a masked request coming back when its enable returns.

// File: rtl/uart_fifo_irq_pkg.sv
package uart_fifo_irq_pkg;
  typedef enum logic [3:0] {
    IID_NONE   = 4'b0001,
    IID_TX     = 4'b0010,
    IID_RX_RDY = 4'b0100,
    IID_RX_TMO = 4'b1100
  } iid_e;
endpackage

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo #(
  parameter int LVL_W   = 7,
  parameter int FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   rx_level_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               bit_tick_i,
  input  logic               rx_char_i,
  input  logic               rx_read_i,
  output logic               tmo_o
);
  // 4*frame + 12 fits in FRAME_W+3 bits for FRAME_W >= 2
  localparam int CNT_W = FRAME_W + 3;

  logic [CNT_W-1:0] idle_cnt;
  logic [CNT_W-1:0] limit;
  logic             restart;

  assign limit   = CNT_W'({frame_bits_i, 2'b00}) + CNT_W'(12);
  assign restart = rx_char_i || rx_read_i || (rx_level_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt <= '0;
      tmo_o    <= 1'b0;
    end else if (restart) begin
      idle_cnt <= '0;
      tmo_o    <= 1'b0;
    end else if (bit_tick_i && !tmo_o) begin
      if (idle_cnt + 1'b1 >= limit) begin
        tmo_o    <= 1'b1;
        idle_cnt <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_irq.sv
module uart_tx_irq #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_trig_i,
  input  logic             tsr_busy_i,
  input  logic             half_duplex_i,
  input  logic             ack_i,
  output logic             pend_o
);
  logic [LVL_W-1:0] prev_level;
  logic             prev_idle;
  logic             idle_now;
  logic             evt_trig, evt_drain, evt_idle, evt;
  logic             clr;

  assign idle_now  = (tx_level_i == '0) && !tsr_busy_i;
  assign evt_trig  = (prev_level > tx_trig_i) && (tx_level_i <= tx_trig_i);
  assign evt_drain = (prev_level != '0) && (tx_level_i == '0);
  assign evt_idle  = idle_now && !prev_idle;
  assign evt       = half_duplex_i ? evt_idle : (evt_trig || evt_drain);
  assign clr       = ack_i || (tx_level_i > prev_level);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_level <= '0;
      prev_idle  <= 1'b1;
      pend_o     <= 1'b0;
    end else begin
      prev_level <= tx_level_i;
      prev_idle  <= idle_now;
      if (evt)      pend_o <= 1'b1;
      else if (clr) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_fifo_irq_pkg::*;
#(
  parameter bit TMO_FIRST = 1'b1
) (
  input  logic tmo_i,
  input  logic rdy_i,
  input  logic tx_i,
  output iid_e id_o,
  output logic irq_o
);
  generate
    if (TMO_FIRST) begin : g_tmo_first
      always_comb begin
        if (tmo_i)      id_o = IID_RX_TMO;
        else if (rdy_i) id_o = IID_RX_RDY;
        else if (tx_i)  id_o = IID_TX;
        else            id_o = IID_NONE;
      end
    end else begin : g_rdy_first
      always_comb begin
        if (rdy_i)      id_o = IID_RX_RDY;
        else if (tmo_i) id_o = IID_RX_TMO;
        else if (tx_i)  id_o = IID_TX;
        else            id_o = IID_NONE;
      end
    end
  endgenerate

  assign irq_o = tmo_i || rdy_i || tx_i;
endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_fifo_irq_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int FRAME_W   = 4,
  parameter bit TMO_FIRST = 1'b1,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LVL_W-1:0]   rx_level_i,
  input  logic [LVL_W-1:0]   tx_level_i,
  input  logic               tsr_busy_i,
  input  logic [LVL_W-1:0]   rx_trig_i,
  input  logic [LVL_W-1:0]   tx_trig_i,
  input  logic [FRAME_W-1:0] frame_bits_i,
  input  logic               bit_tick_i,
  input  logic               rx_char_i,
  input  logic               rx_read_i,
  input  logic               id_read_i,
  input  logic               half_duplex_i,
  input  logic               rx_en_i,
  input  logic               tx_en_i,
  output logic               rx_rdy_irq_o,
  output logic               rx_tmo_irq_o,
  output logic               tx_irq_o,
  output logic               thr_empty_o,
  output logic               tx_empty_o,
  output logic [3:0]         irq_id_o,
  output logic               irq_o
);
  logic tmo_raw;
  logic tx_pend;
  logic tx_ack;
  iid_e iid;

  uart_rx_tmo #(.LVL_W(LVL_W), .FRAME_W(FRAME_W)) u_rx_tmo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_level_i   (rx_level_i),
    .frame_bits_i (frame_bits_i),
    .bit_tick_i   (bit_tick_i),
    .rx_char_i    (rx_char_i),
    .rx_read_i    (rx_read_i),
    .tmo_o        (tmo_raw)
  );

  // acknowledge only when transmit is the code being read
  assign tx_ack = id_read_i && (iid == IID_TX);

  uart_tx_irq #(.LVL_W(LVL_W)) u_tx_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tx_level_i    (tx_level_i),
    .tx_trig_i     (tx_trig_i),
    .tsr_busy_i    (tsr_busy_i),
    .half_duplex_i (half_duplex_i),
    .ack_i         (tx_ack),
    .pend_o        (tx_pend)
  );

  assign rx_rdy_irq_o = rx_en_i && (rx_level_i != '0) && (rx_level_i >= rx_trig_i);
  assign rx_tmo_irq_o = rx_en_i && tmo_raw;
  assign tx_irq_o     = tx_en_i && tx_pend;
  assign thr_empty_o  = (tx_level_i == '0);
  assign tx_empty_o   = thr_empty_o && !tsr_busy_i;

  uart_irq_prio #(.TMO_FIRST(TMO_FIRST)) u_prio (
    .tmo_i (rx_tmo_irq_o),
    .rdy_i (rx_rdy_irq_o),
    .tx_i  (tx_irq_o),
    .id_o  (iid),
    .irq_o (irq_o)
  );

  assign irq_id_o = iid;
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk
  import uart_fifo_irq_pkg::*;
#(
  parameter int LVL_W     = 7,
  parameter bit TMO_FIRST = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] tx_level_i,
  input logic             tsr_busy_i,
  input logic             rx_char_i,
  input logic             rx_read_i,
  input logic             half_duplex_i,
  input logic             rx_rdy_irq_o,
  input logic             rx_tmo_irq_o,
  input logic             thr_empty_o,
  input logic             tx_empty_o,
  input logic [3:0]       irq_id_o,
  input logic             irq_o,
  input logic             tx_pend
);
  assert_rdy_has_data_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rdy_irq_o |-> (rx_level_i != '0));

  assert_tmo_had_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tmo_irq_o |-> ($past(rx_level_i) != '0));

  assert_status_nest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> thr_empty_o);

  assert_hd_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tx_pend) && $past(half_duplex_i)) |-> $past((tx_level_i == '0) && !tsr_busy_i));

  assert_irq_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (irq_id_o != IID_NONE));

  generate
    if (TMO_FIRST) begin : g_tmo_prio
      assert_tmo_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_tmo_irq_o |-> (irq_id_o == IID_RX_TMO));
    end
  endgenerate

  assert_read_clears_tmo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_read_i || rx_char_i) |=> !rx_tmo_irq_o);

  assert_fill_clears_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_i > $past(tx_level_i)) |=> !tx_pend);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.LVL_W(LVL_W), .TMO_FIRST(TMO_FIRST)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rx_level_i    (rx_level_i),
  .tx_level_i    (tx_level_i),
  .tsr_busy_i    (tsr_busy_i),
  .rx_char_i     (rx_char_i),
  .rx_read_i     (rx_read_i),
  .half_duplex_i (half_duplex_i),
  .rx_rdy_irq_o  (rx_rdy_irq_o),
  .rx_tmo_irq_o  (rx_tmo_irq_o),
  .thr_empty_o   (thr_empty_o),
  .tx_empty_o    (tx_empty_o),
  .irq_id_o      (irq_id_o),
  .irq_o         (irq_o),
  .tx_pend       (tx_pend)
);

// File: tb/uart_fifo_irq_tb.sv
`timescale 1ns/1ps
module uart_fifo_irq_tb_top;
  localparam int LVL_W = 7;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LVL_W-1:0] rx_level_i = '0, tx_level_i = '0, rx_trig_i = 7'd4, tx_trig_i = 7'd8;
  logic             tsr_busy_i = 1'b0;
  logic [3:0]       frame_bits_i = 4'd10;
  logic             bit_tick_i = 1'b0, rx_char_i = 1'b0, rx_read_i = 1'b0, id_read_i = 1'b0;
  logic             half_duplex_i = 1'b0, rx_en_i = 1'b1, tx_en_i = 1'b1;
  logic             rx_rdy_irq_o, rx_tmo_irq_o, tx_irq_o, thr_empty_o, tx_empty_o, irq_o;
  logic [3:0]       irq_id_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  uart_fifo_irq dut_i (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      bit_tick_i = 1'b1;
      cyc();
    end
    bit_tick_i = 1'b0;
  endtask

  task automatic pulse_char();
    rx_char_i = 1'b1; cyc(); rx_char_i = 1'b0;
  endtask

  task automatic pulse_read();
    rx_read_i = 1'b1; cyc(); rx_read_i = 1'b0;
  endtask

  task automatic pulse_id();
    id_read_i = 1'b1; cyc(); id_read_i = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    report();
  end

  initial begin
    int trigs [5] = '{1, 4, 8, 14, 64};
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // reset state
    check("R1 reset rdy", rx_rdy_irq_o, 0);
    check("R2 reset tmo", rx_tmo_irq_o, 0);
    check("R5 reset tx", tx_irq_o, 0);
    check("R3 reset thr", thr_empty_o, 1);
    check("R4 reset temt", tx_empty_o, 1);
    check("R7 reset id", irq_id_o, 4'b0001);

    // R1 sweep: all levels against several thresholds
    foreach (trigs[t]) begin
      rx_trig_i = LVL_W'(trigs[t]);
      for (int lvl = 0; lvl <= 64; lvl++) begin
        bit exp;
        rx_level_i = LVL_W'(lvl);
        cyc();
        exp = (lvl != 0) && (lvl >= trigs[t]);
        check("R1 rdy", rx_rdy_irq_o, int'(exp));
        check("R7 id rdy", irq_id_o, exp ? 4'b0100 : 4'b0001);
        check("R7 irq", irq_o, int'(exp));
      end
    end
    // R10 receive mask
    rx_en_i = 1'b0; rx_level_i = 7'd64; cyc();
    check("R10 rx mask", rx_rdy_irq_o, 0);
    rx_en_i = 1'b1; rx_level_i = '0; rx_trig_i = 7'd4;

    // R3/R4 status sweep, level only rises, transmit masked
    tx_en_i = 1'b0;
    for (int lvl = 0; lvl <= 9; lvl++) begin
      for (int b = 0; b < 2; b++) begin
        tx_level_i = LVL_W'(lvl);
        tsr_busy_i = b[0];
        cyc();
        check("R3 thr", thr_empty_o, int'(lvl == 0));
        check("R4 temt", tx_empty_o, int'(lvl == 0 && b == 0));
        check("R10 tx masked", tx_irq_o, 0);
      end
    end
    tsr_busy_i = 1'b0;
    tx_en_i = 1'b1;

    // R5 threshold crossing
    tx_level_i = 7'd12; cyc();
    check("R5 above trig", tx_irq_o, 0);
    tx_level_i = 7'd10; cyc();
    check("R5 above trig", tx_irq_o, 0);
    tx_level_i = 7'd8; cyc();
    check("R5 trig irq", tx_irq_o, 1);
    check("R5 trig thr", thr_empty_o, 0);
    check("R5 trig temt", tx_empty_o, 0);
    check("R7 id tx", irq_id_o, 4'b0010);
    pulse_id();
    check("R9 id ack", tx_irq_o, 0);
    tx_level_i = 7'd5; cyc();
    check("R5 below no evt", tx_irq_o, 0);
    tsr_busy_i = 1'b1; tx_level_i = 7'd0; cyc();
    check("R5 drain irq", tx_irq_o, 1);
    check("R5 drain thr", thr_empty_o, 1);
    check("R4 busy temt", tx_empty_o, 0);
    tsr_busy_i = 1'b0; cyc();
    check("R4 idle temt", tx_empty_o, 1);
    tx_level_i = 7'd3; cyc();
    check("R9 fill clear", tx_irq_o, 0);

    // R9 ack ignored when receive-ready is shown
    tx_level_i = 7'd0; cyc();
    check("R5 drain irq", tx_irq_o, 1);
    rx_level_i = 7'd4; cyc();
    check("R7 rdy over tx", irq_id_o, 4'b0100);
    pulse_id();
    check("R9 no ack", tx_irq_o, 1);
    rx_level_i = 7'd0; cyc();
    check("R7 tx shown", irq_id_o, 4'b0010);
    pulse_id();
    check("R9 ack", tx_irq_o, 0);

    // R10 transmit mask keeps pending
    tx_level_i = 7'd2; cyc();
    tx_en_i = 1'b0; tx_level_i = 7'd0; cyc();
    check("R10 tx mask", tx_irq_o, 0);
    check("R10 id none", irq_id_o, 4'b0001);
    tx_en_i = 1'b1; cyc();
    check("R10 reappear", tx_irq_o, 1);
    tx_level_i = 7'd1; cyc();
    check("R9 fill clear", tx_irq_o, 0);

    // R6 half duplex
    half_duplex_i = 1'b1;
    tx_level_i = 7'd10; tsr_busy_i = 1'b1; cyc();
    tx_level_i = 7'd8; cyc();
    check("R6 no trig", tx_irq_o, 0);
    tx_level_i = 7'd0; cyc();
    check("R6 busy drain", tx_irq_o, 0);
    tsr_busy_i = 1'b0; cyc();
    check("R6 idle irq", tx_irq_o, 1);
    check("R6 temt", tx_empty_o, 1);
    tx_level_i = 7'd1; cyc();
    check("R9 fill clear", tx_irq_o, 0);
    half_duplex_i = 1'b0;

    // R2 timeout, frame 10 -> 52 bit ticks
    rx_level_i = 7'd1;
    pulse_char();
    ticks(51);
    check("R2 before limit", rx_tmo_irq_o, 0);
    ticks(1);
    check("R2 at limit", rx_tmo_irq_o, 1);
    check("R7 id tmo", irq_id_o, 4'b1100);
    pulse_read();
    check("R8 read clears", rx_tmo_irq_o, 0);
    ticks(40);
    pulse_char();
    ticks(40);
    check("R8 restart", rx_tmo_irq_o, 0);
    ticks(12);
    check("R8 restart limit", rx_tmo_irq_o, 1);
    pulse_char();
    check("R8 char clears", rx_tmo_irq_o, 0);

    // frame 8 -> 44 bit ticks
    frame_bits_i = 4'd8;
    pulse_char();
    ticks(43);
    check("R2 f8 before", rx_tmo_irq_o, 0);
    ticks(1);
    check("R2 f8 at", rx_tmo_irq_o, 1);

    // empty FIFO never times out
    rx_level_i = 7'd0; cyc();
    ticks(100);
    check("R2 empty", rx_tmo_irq_o, 0);

    // R7 priority with all three sources
    rx_level_i = 7'd4;
    pulse_char();
    ticks(44);
    tx_level_i = 7'd0; cyc();
    check("R7 all tmo", irq_id_o, 4'b1100);
    check("R1 rdy too", rx_rdy_irq_o, 1);
    check("R5 tx too", tx_irq_o, 1);
    pulse_read();
    check("R7 then rdy", irq_id_o, 4'b0100);
    rx_level_i = 7'd0; cyc();
    check("R7 then tx", irq_id_o, 4'b0010);
    check("R7 irq on", irq_o, 1);

    report();
  end
endmodule